// File: doc/BRIEF.md
# Serial configuration bitstream reader

This block holds a configuration image in an internal word array and streams it one bit per clock to a downstream loader. The loader clocks the block and controls it through two active-low controls. `oe_rst` clears the read position when low and enables output when high. `sel_n` enables the device when low and idles it when high. Each stored word is 16 bits wide and is sent most significant bit first. After the last bit of a word, the next address follows.

When the last bit of the active range has been sent, the block stops driving data and pulls its chain output `chain_n` low. Several readers can therefore share one data line, with each `chain_n` feeding the `sel_n` of the next reader. A paging option splits the array into four equal quarters, and two select inputs choose which quarter is read. A serial-enable input switches the whole read path on or off. The image is loaded through a plain synchronous write port. Tri-state behaviour is represented by a data bit plus a separate drive-enable output.

Top module: `cfg_stream_top`

## Requirements
- R1: While `rst_n` is low, `ready` is 0, `dout_oe` is 0 and `chain_n` is 1. After release, `ready` rises on the POR_CYCLES-th rising clock edge sampled with `rst_n` high. Until then, no data is driven.
- R2: While `stream_en` is 1 and `oe_rst` is 0, `dout_oe` is 0 and `chain_n` is 1 for either level of `sel_n`. On the next edge the read position returns to bit 0 of the range's first word.
- R3: While `stream_en` is 1 and `sel_n` is 1, `standby` is 1, `dout_oe` is 0 and the read position is frozen. Reading resumes at the same bit once `sel_n` returns low.
- R4: With `stream_en`=1, `sel_n`=0, `oe_rst`=1 and `ready`=1, `dout_oe` is 1 and `dout` shows the current bit. The position advances one bit per clock. Bits are sent from bit 15 down to bit 0 of each word, and then the next address follows.
- R5: With `part_en`=0, a read starts at address 0 and covers every address up to 2^ADDR_W-1. `part_sel` has no effect.
- R6: With `part_en`=1, select value s (00, 01, 10, 11) reads addresses s*Q to s*Q+Q-1, where Q=2^ADDR_W/4.
- R7: On the edge after the last bit of the range has been shown, the read stops. From then on `dout_oe` is 0, and `chain_n` is 0 while `sel_n` is 0 and `oe_rst` is 1.
- R8: After the end of the range, `chain_n` follows `sel_n` while `oe_rst` stays 1. Once `oe_rst` goes low, `chain_n` stays 1 until the range has been read to its end again.
- R9: While `stream_en` is 0, `dout_oe` is 0, `chain_n` is 1 and `standby` is 0. The read position is held, and `sel_n`, `part_en` and `part_sel` do not affect it.
- R10: A write with `wr_en`=1 stores `wr_data` at `wr_addr` on the rising edge, and a later read returns that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock from the loader |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| stream_en | input | 1 | Serial read path enable, active high |
| sel_n | input | 1 | Device enable, active low |
| oe_rst | input | 1 | Low: clear position; high: allow output |
| part_en | input | 1 | Paging enable |
| part_sel | input | 2 | Quarter select when paging |
| wr_en | input | 1 | Image write strobe |
| wr_addr | input | ADDR_W | Image write address |
| wr_data | input | 16 | Image write word |
| dout | output | 1 | Current serial data bit |
| dout_oe | output | 1 | Data drive enable (0 = high impedance) |
| chain_n | output | 1 | Chain output to next reader, active low |
| standby | output | 1 | Idle indication while deselected |
| ready | output | 1 | Power-on sequence complete |

## Verification
The hardest state to reach is the cascade sequence after the end of a range. Reaching it needs the whole range read out, and then the `sel_n` and `oe_rst` levels walked in order. The stimulus reads the whole array once and each quarter once, with a scoreboard checking every bit. It then toggles `sel_n`, drops `oe_rst` and restarts, showing `chain_n` stays high after the restart. Pauses through `sel_n` and `stream_en` are inserted in the middle of full reads, so a frozen position can only be told apart from a reset one by the bit order that follows.

// File: rtl/cfg_stream_pkg.sv
// Shared constants for the serial configuration reader.
// Assumes a fixed 16-bit stored word; the bit index width follows from it.
package cfg_stream_pkg;
    localparam int WORD_W = 16;
    localparam int BIT_W  = $clog2(WORD_W);
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BIT_W-1:0]  bit_idx_t;
    localparam bit_idx_t LAST_BIT = bit_idx_t'(WORD_W - 1);
endpackage

// File: rtl/cfg_por.sv
// Power-on sequencer: holds ready low for POR_CYCLES edges after rst_n release.
// Assumes rst_n is synchronous and active low.
module cfg_por #(
    parameter int POR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    generate
        if (POR_CYCLES <= 1) begin : g_short
            // Purpose: raise ready on the first edge out of reset.
            always_ff @(posedge clk) begin
                if (!rst_n) ready <= 1'b0;
                else        ready <= 1'b1;
            end
        end else begin : g_count
            localparam int CNT_W = $clog2(POR_CYCLES);
            logic [CNT_W-1:0] cnt;
            // Purpose: count edges since release and flag completion.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt   <= '0;
                    ready <= 1'b0;
                end else if (!ready) begin
                    cnt   <= cnt + 1'b1;
                    ready <= (cnt == CNT_W'(POR_CYCLES - 1));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cfg_store.sv
// Image array: synchronous write port, combinational bit read, MSB first.
// Assumes the array contents are not reset; they are loaded before use.
module cfg_store
    import cfg_stream_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  bit_idx_t          rd_bit,
    output logic              rd_val
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t    mem [DEPTH];
    word_t    rd_word;
    bit_idx_t pos;

    // Purpose: store one image word per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Purpose: pick the bit at the current position, highest bit first.
    always_comb begin
        rd_word = mem[rd_addr];
        pos     = LAST_BIT - rd_bit;
        rd_val  = rd_word[pos];
    end
endmodule

// File: rtl/cfg_seq.sv
// Read position sequencer: address and bit counters, range decode, end flag.
// Assumes ADDR_W >= 2 so the array splits into four equal quarters.
module cfg_seq
    import cfg_stream_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              stream_en,
    input  logic              sel_n,
    input  logic              oe_rst,
    input  logic              part_en,
    input  logic [1:0]        part_sel,
    output logic [ADDR_W-1:0] addr,
    output bit_idx_t          bitc,
    output logic              done
);
    localparam int QTR_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] top_addr;
    logic              clear;
    logic              run;
    logic              last;

    // Purpose: decode the first and last address of the selected range.
    always_comb begin
        if (part_en) begin
            base_addr = {part_sel, {QTR_W{1'b0}}};
            top_addr  = {part_sel, {QTR_W{1'b1}}};
        end else begin
            base_addr = '0;
            top_addr  = '1;
        end
        clear = !rst_n || !ready || (stream_en && !oe_rst);
        run   = stream_en && !sel_n && oe_rst && !done;
        last  = (addr == top_addr) && (bitc == LAST_BIT);
    end

    // Purpose: clear, hold or step the read position and latch the end.
    always_ff @(posedge clk) begin
        if (clear) begin
            addr <= base_addr;
            bitc <= '0;
            done <= 1'b0;
        end else if (run) begin
            if (last) begin
                done <= 1'b1;
            end else begin
                bitc <= bitc + 1'b1;
                if (bitc == LAST_BIT) addr <= addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_stream_top.sv
// Serial configuration reader top: ties sequencer, array and power-on logic,
// and forms data drive, chain output and standby flag.
// Assumes the loader supplies clk and the active-low controls synchronously.
module cfg_stream_top
    import cfg_stream_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int POR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stream_en,
    input  logic              sel_n,
    input  logic              oe_rst,
    input  logic              part_en,
    input  logic [1:0]        part_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output logic              dout,
    output logic              dout_oe,
    output logic              chain_n,
    output logic              standby,
    output logic              ready
);
    logic [ADDR_W-1:0] seq_addr;
    bit_idx_t          seq_bit;
    logic              seq_done;
    logic              cur_bit;
    logic              selected;

    cfg_por #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    cfg_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .stream_en (stream_en),
        .sel_n     (sel_n),
        .oe_rst    (oe_rst),
        .part_en   (part_en),
        .part_sel  (part_sel),
        .addr      (seq_addr),
        .bitc      (seq_bit),
        .done      (seq_done)
    );

    cfg_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (seq_addr),
        .rd_bit  (seq_bit),
        .rd_val  (cur_bit)
    );

    // Purpose: form the output drive, chain and standby indications.
    always_comb begin
        selected = stream_en && ready && oe_rst && !sel_n;
        dout_oe  = selected && !seq_done;
        dout     = dout_oe && cur_bit;
        chain_n  = !(selected && seq_done);
        standby  = stream_en && sel_n;
    end
endmodule

// File: rtl/cfg_stream_chk.sv
// Property checker for cfg_stream_top, attached by bind below.
module cfg_stream_chk
    import cfg_stream_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stream_en,
    input logic              sel_n,
    input logic              oe_rst,
    input logic              ready,
    input logic              dout_oe,
    input logic              chain_n,
    input logic              standby,
    input logic [ADDR_W-1:0] addr,
    input bit_idx_t          bitc,
    input logic              done
);
    // R1: nothing driven before the power-on sequence completes
    a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!dout_oe && chain_n));

    // R2: reset level on oe_rst silences data and chain
    a_r2_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_en && !oe_rst) |-> (!dout_oe && chain_n));

    // R3: deselected device keeps its read position
    a_r3_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_en && sel_n && oe_rst && ready) |=> ($stable(addr) && $stable(bitc)));

    // R4: a driven bit is followed by the next bit or the end of range
    a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |=> (done || (bitc == ($past(bitc) + 4'd1))));

    // R7: chain asserted implies data released
    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_n |-> !dout_oe);

    // R9: serial path off drives nothing
    a_r9_path_off: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_en |-> (!dout_oe && chain_n && !standby));
endmodule

bind cfg_stream_top cfg_stream_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stream_en (stream_en),
    .sel_n     (sel_n),
    .oe_rst    (oe_rst),
    .ready     (ready),
    .dout_oe   (dout_oe),
    .chain_n   (chain_n),
    .standby   (standby),
    .addr      (seq_addr),
    .bitc      (seq_bit),
    .done      (seq_done)
);

// File: tb/sim_cfg_stream_top.sv
`timescale 1ns/100ps
module sim_cfg_stream_top;
    localparam int ADDR_W = 8;
    localparam int POR    = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int QTR    = DEPTH / 4;

    logic              clk = 1'b0;
    logic              rst_n, stream_en, sel_n, oe_rst, part_en, wr_en;
    logic [1:0]        part_sel;
    logic [ADDR_W-1:0] wr_addr;
    logic [15:0]       wr_data;
    logic              dout, dout_oe, chain_n, standby, ready;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    exp_q[$];
    string cur_tag = "R4";

    always #2.5 clk = ~clk;

    cfg_stream_top #(.ADDR_W(ADDR_W), .POR_CYCLES(POR)) u0 (
        .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .sel_n(sel_n),
        .oe_rst(oe_rst), .part_en(part_en), .part_sel(part_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dout(dout), .dout_oe(dout_oe), .chain_n(chain_n),
        .standby(standby), .ready(ready)
    );

    function automatic logic [15:0] pat(int a);
        logic [15:0] v;
        v = 16'(a) * 16'h2F1B;
        return v ^ 16'hC3A5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Driver side of the scoreboard: expected bits of a word range, MSB first.
    task automatic push_words(input int first, input int count);
        for (int a = first; a < first + count; a++)
            for (int b = 15; b >= 0; b--)
                exp_q.push_back(pat(a)[b]);
    endtask

    // Monitor: every driven bit must match the next expected one.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && dout_oe === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected driven bit", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                chk(dout === e, cur_tag, "dout", int'(dout), int'(e));
            end
        end
    end

    // Run a range read from a cleared position to its end, then check the end.
    task automatic full_read(input string tag, input int first, input int count);
        cur_tag = tag;
        oe_rst = 1'b0;
        tick(2);
        push_words(first, count);
        oe_rst = 1'b1;
        tick(count * 16);
        @(negedge clk);
        chk(exp_q.size() == 0, tag, "bits left", exp_q.size(), 0);
        chk(chain_n == 1'b0, "R7", "chain_n at end", int'(chain_n), 0);
        chk(dout_oe == 1'b0, "R7", "dout_oe at end", int'(dout_oe), 0);
        tick();
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; stream_en = 1'b1; sel_n = 1'b0; oe_rst = 1'b1;
        part_en = 1'b0; part_sel = 2'b00; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        tick(3);
        @(negedge clk);
        // R1: reset state
        chk(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
        chk(dout_oe == 1'b0, "R1", "dout_oe in reset", int'(dout_oe), 0);
        chk(chain_n == 1'b1, "R1", "chain_n in reset", int'(chain_n), 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int i = 1; i < POR; i++) begin
            tick();
            @(negedge clk);
            chk(ready == 1'b0, "R1", "ready early", int'(ready), 0);
        end
        tick();
        @(negedge clk);
        chk(ready == 1'b1, "R1", "ready after count", int'(ready), 1);

        // R10: load the image with the read path cleared
        oe_rst = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            tick();
            wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = pat(a);
        end
        tick();
        wr_en = 1'b0;

        // R5: paging off, select ignored, whole array; also covers R10 and R4
        part_sel = 2'b11;
        full_read("R5", 0, DEPTH);

        // R8: chain follows sel_n, then stays high after oe_rst low
        sel_n = 1'b1; tick();
        @(negedge clk);
        chk(chain_n == 1'b1, "R8", "chain_n follows sel high", int'(chain_n), 1);
        sel_n = 1'b0; tick();
        @(negedge clk);
        chk(chain_n == 1'b0, "R8", "chain_n follows sel low", int'(chain_n), 0);
        oe_rst = 1'b0; tick();
        @(negedge clk);
        chk(chain_n == 1'b1, "R8", "chain_n with oe low", int'(chain_n), 1);
        cur_tag = "R8";
        push_words(0, 1);
        void'(exp_q.pop_back()); // keep only the first bit
        for (int k = 0; k < 14; k++) void'(exp_q.pop_back());
        tick();
        oe_rst = 1'b1;
        @(negedge clk);
        chk(chain_n == 1'b1, "R8", "chain_n after restart", int'(chain_n), 1);
        tick();
        oe_rst = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, "R8", "restart bit consumed", exp_q.size(), 0);

        // R6: each quarter with paging on
        part_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            part_sel = 2'(s);
            full_read("R6", s * QTR, QTR);
        end

        // R3: pause through sel_n in the middle of a quarter
        part_sel = 2'b01;
        cur_tag = "R3";
        oe_rst = 1'b0; tick(2);
        push_words(QTR, QTR);
        oe_rst = 1'b1;
        tick(100);
        sel_n = 1'b1;
        tick(3);
        @(negedge clk);
        chk(standby == 1'b1, "R3", "standby", int'(standby), 1);
        chk(dout_oe == 1'b0, "R3", "dout_oe paused", int'(dout_oe), 0);
        chk(exp_q.size() == QTR * 16 - 100, "R3", "bits shown before pause",
            exp_q.size(), QTR * 16 - 100);
        tick();
        sel_n = 1'b0;
        tick(QTR * 16);
        @(negedge clk);
        chk(exp_q.size() == 0, "R3", "resumed to end", exp_q.size(), 0);
        chk(chain_n == 1'b0, "R7", "chain_n after paused read", int'(chain_n), 0);

        // R9: serial path off mid-read, select and paging changed meanwhile
        part_sel = 2'b10;
        cur_tag = "R9";
        tick();
        oe_rst = 1'b0; tick(2);
        push_words(2 * QTR, QTR);
        oe_rst = 1'b1;
        tick(50);
        stream_en = 1'b0;
        tick();
        part_sel = 2'b00; part_en = 1'b0; sel_n = 1'b1;
        tick(2);
        sel_n = 1'b0;
        tick(2);
        @(negedge clk);
        chk(dout_oe == 1'b0, "R9", "dout_oe path off", int'(dout_oe), 0);
        chk(chain_n == 1'b1, "R9", "chain_n path off", int'(chain_n), 1);
        chk(standby == 1'b0, "R9", "standby path off", int'(standby), 0);
        tick();
        part_sel = 2'b10; part_en = 1'b1;
        tick();
        stream_en = 1'b1;
        tick(QTR * 16);
        @(negedge clk);
        chk(exp_q.size() == 0, "R9", "position held while off", exp_q.size(), 0);

        // R2: clear mid-read with sel_n high, then restart from the first word
        part_en = 1'b0;
        cur_tag = "R2";
        tick();
        oe_rst = 1'b0; tick(2);
        push_words(0, 3);
        for (int k = 0; k < 8; k++) void'(exp_q.pop_back());
        oe_rst = 1'b1;
        tick(40);
        oe_rst = 1'b0; sel_n = 1'b1;
        @(negedge clk);
        chk(dout_oe == 1'b0, "R2", "dout_oe clear", int'(dout_oe), 0);
        chk(chain_n == 1'b1, "R2", "chain_n clear", int'(chain_n), 1);
        chk(exp_q.size() == 0, "R2", "bits before clear", exp_q.size(), 0);
        tick(2);
        sel_n = 1'b0;
        push_words(0, 1);
        oe_rst = 1'b1;
        tick(16);
        oe_rst = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, "R2", "restart from base", exp_q.size(), 0);
        tick(2);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule